// File: doc/BRIEF.md
# Burst-of-four dual-port synchronous SRAM

This block models a synchronous SRAM with a write port and a read port that are fully independent and may both start a transfer in the same cycle. Each transfer is a burst of four data beats. Two beats cross the narrow data bus in each clock cycle, which stands in for data on both clock edges, so one burst takes two cycles. An array word is as wide as all four beats together. One address selects one such word.

On the write side, the first cycle of a burst registers the address, the first two beats and their byte enables. In the second cycle the last two beats arrive, and the whole word is merged byte by byte with the stored word and written in a single array write. A byte enable is given with each beat, not with the command. On the read side, one array word is captured into an output register. A multiplexer then presents it as two beat pairs on consecutive cycles, with a valid flag and a phase flag.

A read that is captured while a write to the same address is finishing returns the merged word from that write. A read therefore always sees every write whose command came no later than its own.

Top module: `bq_sram`

## Requirements
- R1: While reset is asserted and after its release, rd_valid, rd_phase and rd_data are all 0 until a read is accepted.
- R2: wr_req is accepted when no write burst is in its second cycle. The accepting cycle carries beats 0 (bits DW-1:0) and 1 (upper half) on wr_data. The next cycle carries beats 2 and 3 the same way. A wr_req raised in that second cycle is ignored and writes nothing.
- R3: Bit b of wr_be enables byte b of the beat pair on wr_data in the same cycle. A byte with its enable at 0 keeps its old array value, and an all-zero mask leaves the word unchanged.
- R4: A read accepted in cycle T drives rd_valid=1, rd_phase=0 and beats 1:0 in cycle T+2, then rd_valid=1, rd_phase=1 and beats 3:2 in cycle T+3.
- R5: rd_valid is 1 for exactly two cycles per accepted read, and rd_data is 0 whenever rd_valid is 0.
- R6: A rd_req in the cycle right after an accepted read is ignored and produces no burst.
- R7: A read and a write to different addresses started in the same cycle do not disturb each other.
- R8: A read sees every write whose command came in the same cycle as the read or earlier, byte merge included. A read issued one cycle before a write command returns the old word.
- R9: Reads issued every second cycle give an unbroken run of valid beats, and writes may be issued every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two beats per period |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| wr_req | input | 1 | Start a write burst |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 2*DW | Two write beats (even beat in the low half) |
| wr_be | input | 2*DW/8 | Byte enables for the two beats on wr_data |
| rd_req | input | 1 | Start a read burst |
| rd_addr | input | AW | Word address of the read |
| rd_valid | output | 1 | Read beats present on rd_data |
| rd_phase | output | 1 | 0: beats 1:0, 1: beats 3:2 |
| rd_data | output | 2*DW | Two read beats (even beat in the low half) |

## Verification
Write results can only be seen through a later read, so every write is followed by a read of the same word. Read results are due exactly two and three cycles after the read command, and the cycle after that must show rd_valid low. The bench drives every command one nanosecond after a rising edge and samples at that same point in each counted cycle. The coherence cases place the read in the same cycle as the write command, and one cycle before it, and the expected words for both come from a byte-merge model of the array kept in the bench.

// File: rtl/bq_sram.sv
module bq_sram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [AW-1:0]         wr_addr,
  input  logic [2*DW-1:0]       wr_data,
  input  logic [2*(DW/8)-1:0]   wr_be,
  input  logic                  rd_req,
  input  logic [AW-1:0]         rd_addr,
  output logic                  rd_valid,
  output logic                  rd_phase,
  output logic [2*DW-1:0]       rd_data
);
  localparam int BW    = DW / 8;
  localparam int NB    = 4 * BW;
  localparam int HW    = 2 * DW;
  localparam int WW    = 4 * DW;
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  // write side: collect the first beat pair, merge and commit with the second
  logic            wr_ph;
  logic [AW-1:0]   wa_q;
  logic [HW-1:0]   wd_q;
  logic [2*BW-1:0] wb_q;
  logic            wr_go;
  logic [WW-1:0]   wword, wold, wnew;
  logic [NB-1:0]   wmask;

  assign wr_go = wr_req & ~wr_ph;
  assign wword = {wr_data, wd_q};
  assign wmask = {wr_be, wb_q};
  assign wold  = mem[wa_q];

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign wnew[8*b +: 8] = wmask[b] ? wword[8*b +: 8] : wold[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ph <= 1'b0;
      wa_q  <= '0;
      wd_q  <= '0;
      wb_q  <= '0;
    end else begin
      wr_ph <= wr_go;
      if (wr_go) begin
        wa_q <= wr_addr;
        wd_q <= wr_data;
        wb_q <= wr_be;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ph) mem[wa_q] <= wnew;
  end

  // read side: capture one word, forward a finishing write, step out two pairs
  logic          rd_cap, rv0, rv1, rd_go, hit;
  logic [AW-1:0] ra_q;
  logic [WW-1:0] rq, rword;

  assign rd_go = rd_req & ~rd_cap;
  assign hit   = wr_ph && (wa_q == ra_q);
  assign rword = hit ? wnew : mem[ra_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cap <= 1'b0;
      ra_q   <= '0;
      rv0    <= 1'b0;
      rv1    <= 1'b0;
      rq     <= '0;
    end else begin
      rd_cap <= rd_go;
      rv0    <= rd_cap;
      rv1    <= rv0;
      if (rd_go)  ra_q <= rd_addr;
      if (rd_cap) rq   <= rword;
    end
  end

  assign rd_valid = rv0 | rv1;
  assign rd_phase = rv1;
  assign rd_data  = rv0 ? rq[HW-1:0] : (rv1 ? rq[WW-1:HW] : '0);

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_cap) |=> ##1 (rd_valid && !rd_phase));
  assert_second_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_phase) |=> (rd_valid && rd_phase));
  assert_pairs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rv0, rv1}));
  assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
  assert_read_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> !rd_cap);
  assert_write_second_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ph) |=> wr_ph);
  assert_write_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ph |=> !wr_ph);
endmodule

// File: tb/bq_sram_tb.sv
`timescale 1ns/1ps
module bq_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0, rd_req = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_valid, rd_phase;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] model [16];

  always #2 clk = ~clk;

  bq_sram #(.DW(16), .AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_phase(rd_phase), .rd_data(rd_data));

  // addr, data, byte mask
  localparam logic [75:0] VEC [6] = '{
    {4'h1, 64'h1111_2222_3333_4444, 8'hFF},
    {4'h2, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F},
    {4'h2, 64'h0123_4567_89AB_CDEF, 8'hF0},
    {4'h3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h55},
    {4'h3, 64'h0000_0000_0000_0000, 8'hAA},
    {4'h4, 64'h9999_8888_7777_6666, 8'h00}
  };

  function automatic logic [63:0] merge(logic [63:0] o, logic [63:0] n, logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = m[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit dr, input logic [3:0] ra, input bit dw, input logic [3:0] wa,
                       input logic [63:0] wd, input logic [7:0] be,
                       input bit hr, input logic [3:0] ra2, input bit hw, input logic [3:0] wa2);
    rd_req = dr; rd_addr = ra; wr_req = dw; wr_addr = wa; wr_data = wd[31:0]; wr_be = be[3:0];
    tick();
    rd_req = hr; rd_addr = ra2; wr_req = hw; wr_addr = wa2; wr_data = wd[63:32]; wr_be = be[7:4];
    tick();
    rd_req = 0; wr_req = 0; wr_data = '0; wr_be = '0;
    if (dw) model[wa] = merge(model[wa], wd, be);
  endtask

  // called in cycle T+2 of a read; returns the word and whether the framing was right
  task automatic collect(output logic [63:0] w, output bit ok);
    ok = rd_valid && !rd_phase;
    w[31:0] = rd_data;
    tick();
    ok = ok && rd_valid && rd_phase;
    w[63:32] = rd_data;
    tick();
    ok = ok && !rd_valid && rd_data == '0;
  endtask

  task automatic readback(input logic [3:0] a, input string req);
    logic [63:0] w; bit ok;
    issue(1, a, 0, 0, 0, 0, 0, 0, 0, 0);
    collect(w, ok);
    chk(ok, "R4 R5 framing", {63'd0, ok}, 64'd1);
    chk(w == model[a], req, w, model[a]);
  endtask

  initial begin
    logic [63:0] w, exp; bit ok;
    // R1: reset state
    #1;
    chk(!rd_valid && !rd_phase && rd_data == '0, "R1 during reset", {rd_valid, rd_phase, rd_data}, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    chk(!rd_valid && !rd_phase && rd_data == '0, "R1 after reset", {rd_valid, rd_phase, rd_data}, 0);

    // prefill every word with a full-mask write, issued back to back (R9)
    for (int a = 0; a < 16; a++)
      issue(0, 0, 1, 4'(a), 64'h0123_4567_89AB_CDEF ^ {16{4'(a)}}, 8'hFF, 0, 0, 0, 0);
    for (int a = 0; a < 16; a += 5) readback(4'(a), "R9 R2 back-to-back writes");

    // vector table: masked writes then readback (R2, R3; mask 00 = no effect)
    for (int i = 0; i < 6; i++) begin
      issue(0, 0, 1, VEC[i][75:72], VEC[i][71:8], VEC[i][7:0], 0, 0, 0, 0);
      readback(VEC[i][75:72], "R3 byte-masked write");
    end

    // R7: read and write to different words in the same cycle
    exp = model[5];
    issue(1, 4'd5, 1, 4'd3, 64'hA5A5_5A5A_C3C3_3C3C, 8'hFF, 0, 0, 0, 0);
    collect(w, ok);
    chk(ok && w == exp, "R7 parallel read unaffected", w, exp);
    readback(4'd3, "R7 parallel write landed");

    // R8: read issued with the write command to the same word sees the merge
    issue(1, 4'd9, 1, 4'd9, 64'h7777_6666_5555_4444, 8'h3C, 0, 0, 0, 0);
    collect(w, ok);
    chk(ok && w == model[9], "R8 same-cycle forwarding", w, model[9]);

    // R8: read one cycle before the write command returns the old word
    exp = model[10];
    rd_req = 1; rd_addr = 4'd10;
    tick();
    rd_req = 0; wr_req = 1; wr_addr = 4'd10; wr_data = 32'hBBBB_AAAA; wr_be = 4'hF;
    tick();
    w[31:0] = rd_data; ok = rd_valid && !rd_phase;
    wr_req = 0; wr_data = 32'hDDDD_CCCC; wr_be = 4'hF;
    tick();
    w[63:32] = rd_data; ok = ok && rd_valid && rd_phase;
    wr_data = '0; wr_be = '0;
    tick();
    chk(ok && w == exp, "R8 read before write sees old", w, exp);
    model[10] = 64'hDDDD_CCCC_BBBB_AAAA;
    readback(4'd10, "R8 later read sees new");

    // R6: second read request in the capture cycle is ignored
    issue(1, 4'd1, 0, 0, 0, 0, 1, 4'd2, 0, 0);
    collect(w, ok);
    chk(ok && w == model[1], "R6 first read intact", w, model[1]);
    tick();
    chk(!rd_valid, "R6 no extra burst", {63'd0, rd_valid}, 0);

    // R2: write request in the second beat cycle is ignored
    exp = model[6];
    issue(0, 0, 1, 4'd4, 64'h1234_1234_1234_1234, 8'hFF, 0, 0, 1, 4'd6);
    readback(4'd6, "R2 ignored write left word");
    chk(model[6] == exp, "R2 model unchanged", model[6], exp);
    readback(4'd4, "R2 accepted write");

    // R9: reads every second cycle give continuous valid beats
    rd_req = 1; rd_addr = 4'd7;
    tick();
    rd_req = 0;
    tick();
    w[31:0] = rd_data; ok = rd_valid && !rd_phase;
    rd_req = 1; rd_addr = 4'd8;
    tick();
    w[63:32] = rd_data; ok = ok && rd_valid && rd_phase;
    rd_req = 0;
    chk(ok && w == model[7], "R9 first of pair", w, model[7]);
    tick();
    w[31:0] = rd_data; ok = rd_valid && !rd_phase;
    tick();
    w[63:32] = rd_data; ok = ok && rd_valid && rd_phase;
    chk(ok && w == model[8], "R9 second of pair", w, model[8]);
    tick();
    chk(!rd_valid && rd_data == '0, "R5 idle after bursts", {rd_valid, rd_data}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule